// File: doc/BRIEF.md
# Microprogrammed Waveform Timing Sequencer

This block generates the digital clock and control pattern for a pixel readout chain. A small program memory holds instructions, and a pattern memory holds waveform words. Each pattern word describes one pixel cycle as 48 time slots, and each slot carries the level of every one of the 16 control lines. When a read instruction executes, the addressed word is played onto the lines one slot per clock. Jump and loop instructions let a short program repeat rows of pixel cycles. A halt instruction or a stop input parks the lines at a programmable idle level.

There are three kinds of read instruction. A plain read refuses external commands while its word plays. A pass read accepts commands on a valid/ready port and forwards each accepted command one clock later. A command read presents a command code, taken from the instruction itself, on a system command output in the same clock as its first slot. The program memory, the pattern memory and the idle level can only be loaded while the sequencer is halted.

Top module: `wave_seq`

## Requirements
- R1: After reset the sequencer is halted, `lines` shows the idle level (reset value 0), and `ext_ready`, `fwd_valid` and `sys_valid` are low.
- R2: A `start` pulse sampled while halted begins execution at program address 0. `lines` shows the idle level for the two clocks that follow. Slot k of the first read's word then appears after the (k+2)th rising edge counted from the edge that sampled `start`.
- R3: Two read instructions at consecutive addresses play with no gap: slot 0 of the second word follows slot 47 of the first directly. Slots always play in order from 0 to 47.
- R4: A jump (opcode 1 in bits [15:13], target address in bits [4:0]) takes one clock. After a word, a jump followed by a read holds the last slot's level for two clocks before the new word starts.
- R5: A loop (opcode 2, repeat count in bits [12:5], body start address in bits [4:0]) runs its body count+1 times in total and then falls through. Each taken or falling-through loop costs one clock in which the lines hold their level.
- R6: A halt (opcode 0) stops execution, and `lines` returns to the idle level one clock after the last slot. While halted, writing `idle_wdata` with `idle_we` changes `lines` one clock later.
- R7: `stop` sampled while running halts the sequencer at that edge, and `lines` shows the idle level from then on.
- R8: A plain read (opcode 3, word in bits [3:0]) keeps `ext_ready` low for the whole of its word. No command is forwarded, even if `ext_valid` is high.
- R9: A pass read (opcode 4, word in bits [3:0]) plays exactly like a plain read. `ext_ready` is high from the clock before its slot 0 up to the clock of its slot 46. Each command accepted there appears on `fwd_valid`/`fwd_data` one clock later.
- R10: A command read (opcode 5, command in bits [11:4], word in bits [3:0]) plays its word and pulses `sys_valid` for one clock together with slot 0, with `sys_cmd` equal to the command field.
- R11: Writes to the program memory, the pattern memory and the idle level are ignored while the sequencer is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin execution at address 0 (while halted) |
| stop | input | 1 | Abort execution and park the lines |
| prog_we | input | 1 | Program memory write enable |
| prog_waddr | input | 5 | Program memory write address |
| prog_wdata | input | 16 | Instruction to write |
| pat_we | input | 1 | Pattern memory write enable |
| pat_wword | input | 4 | Pattern word to write |
| pat_wslot | input | 6 | Slot within the word to write |
| pat_wdata | input | 16 | Line levels for that slot |
| idle_we | input | 1 | Idle level write enable |
| idle_wdata | input | 16 | Idle line levels |
| ext_valid | input | 1 | External command offered |
| ext_data | input | 8 | External command code |
| ext_ready | output | 1 | External command can be accepted |
| fwd_valid | output | 1 | Forwarded command strobe |
| fwd_data | output | 8 | Forwarded command code |
| sys_valid | output | 1 | Instruction-issued command strobe |
| sys_cmd | output | 8 | Instruction-issued command code |
| lines | output | 16 | Control line levels |

## Verification
A wrong program counter, slot counter or word register shows up on `lines` in the very next clock. Every slot value is distinct, so a skipped, repeated or mis-addressed slot differs from the expected level at once. A loop counter that is off by one shows up as one body pass too many or too few, about fifty clocks late, when the idle level or a stray word appears where the other was due. A wrong read mode shows on `ext_ready` or `sys_valid` in the first clock of the affected word, and on `fwd_valid` one clock after that.

// File: rtl/wave_seq.sv
module wave_seq #(
  parameter int NLINES = 16,
  parameter int NSLOTS = 48,
  parameter int NWORDS = 16,
  parameter int PDEPTH = 32,
  parameter int CNT_W  = 8,
  parameter int CMD_W  = 8,
  localparam int PA_W = $clog2(PDEPTH),
  localparam int WA_W = $clog2(NWORDS),
  localparam int SL_W = $clog2(NSLOTS),
  localparam int IW   = 3 + CNT_W + PA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              stop,
  input  logic              prog_we,
  input  logic [PA_W-1:0]   prog_waddr,
  input  logic [IW-1:0]     prog_wdata,
  input  logic              pat_we,
  input  logic [WA_W-1:0]   pat_wword,
  input  logic [SL_W-1:0]   pat_wslot,
  input  logic [NLINES-1:0] pat_wdata,
  input  logic              idle_we,
  input  logic [NLINES-1:0] idle_wdata,
  input  logic              ext_valid,
  input  logic [CMD_W-1:0]  ext_data,
  output logic              ext_ready,
  output logic              fwd_valid,
  output logic [CMD_W-1:0]  fwd_data,
  output logic              sys_valid,
  output logic [CMD_W-1:0]  sys_cmd,
  output logic [NLINES-1:0] lines
);
  localparam logic [2:0] OP_JMP = 3'd1, OP_LOOP = 3'd2, OP_RD = 3'd3,
                         OP_RDP = 3'd4, OP_RDC = 3'd5;

  logic [IW-1:0]     prog_mem [PDEPTH];
  logic [NLINES-1:0] pat_mem  [NWORDS][NSLOTS];

  logic              run_q, play_q, loop_q;
  logic [PA_W-1:0]   pc_q;
  logic [WA_W-1:0]   word_q;
  logic [SL_W-1:0]   slot_q;
  logic [2:0]        mode_q;
  logic [CMD_W-1:0]  cmd_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [NLINES-1:0] lines_q, idle_q;

  logic [IW-1:0]    instr;
  logic [2:0]       op;
  logic [CNT_W-1:0] icnt;
  logic [PA_W-1:0]  itgt;
  logic             is_rd, last_slot, fetch;

  assign instr     = prog_mem[pc_q];
  assign op        = instr[IW-1 -: 3];
  assign icnt      = instr[PA_W +: CNT_W];
  assign itgt      = instr[PA_W-1:0];
  assign is_rd     = (op == OP_RD) || (op == OP_RDP) || (op == OP_RDC);
  assign last_slot = slot_q == SL_W'(NSLOTS - 1);
  assign fetch     = run_q && (!play_q || last_slot);
  assign ext_ready = run_q && play_q && (mode_q == OP_RDP);
  assign lines     = run_q ? lines_q : idle_q;

  always_ff @(posedge clk) begin
    if (!run_q && prog_we) prog_mem[prog_waddr] <= prog_wdata;
    if (!run_q && pat_we && (pat_wslot < SL_W'(NSLOTS))) pat_mem[pat_wword][pat_wslot] <= pat_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0; play_q <= 1'b0; loop_q <= 1'b0; pc_q <= '0;
      word_q <= '0; slot_q <= '0; mode_q <= '0; cmd_q <= '0; cnt_q <= '0;
      lines_q <= '0; idle_q <= '0;
      fwd_valid <= 1'b0; fwd_data <= '0; sys_valid <= 1'b0; sys_cmd <= '0;
    end else begin
      fwd_valid <= ext_valid && ext_ready;
      if (ext_valid && ext_ready) fwd_data <= ext_data;
      sys_valid <= run_q && !stop && play_q && (slot_q == '0) && (mode_q == OP_RDC);
      if (run_q && play_q && (slot_q == '0) && (mode_q == OP_RDC)) sys_cmd <= cmd_q;

      if (!run_q) begin
        if (idle_we) idle_q <= idle_wdata;
        if (start) begin
          run_q <= 1'b1; pc_q <= '0; play_q <= 1'b0; loop_q <= 1'b0;
          slot_q <= '0; lines_q <= idle_q;
        end
      end else if (stop) begin
        run_q <= 1'b0; play_q <= 1'b0; slot_q <= '0;
      end else begin
        if (play_q) begin
          lines_q <= pat_mem[word_q][slot_q];
          slot_q  <= slot_q + 1'b1;
        end
        if (fetch) begin
          if (is_rd) begin
            play_q <= 1'b1;
            word_q <= instr[WA_W-1:0];
            cmd_q  <= instr[WA_W +: CMD_W];
            mode_q <= op;
            slot_q <= '0;
            pc_q   <= pc_q + 1'b1;
          end else if (play_q) begin
            play_q <= 1'b0;
            slot_q <= '0;
          end else begin
            case (op)
              OP_JMP: pc_q <= itgt;
              OP_LOOP: begin
                if (!loop_q) begin
                  if (icnt != '0) begin
                    loop_q <= 1'b1; cnt_q <= icnt - 1'b1; pc_q <= itgt;
                  end else pc_q <= pc_q + 1'b1;
                end else if (cnt_q == '0) begin
                  loop_q <= 1'b0; pc_q <= pc_q + 1'b1;
                end else begin
                  cnt_q <= cnt_q - 1'b1; pc_q <= itgt;
                end
              end
              default: run_q <= 1'b0;
            endcase
          end
        end
      end
    end
  end

  p_start_at_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && start) |=> (run_q && pc_q == '0 && !play_q));
  p_slot_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    slot_q < SL_W'(NSLOTS));
  p_stop_parks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && stop) |=> (!run_q && lines == idle_q));
  p_fwd_after_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> $past(ext_valid && ext_ready));
  p_sys_single_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sys_valid |=> !sys_valid);
  p_idle_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |=> $stable(idle_q));
endmodule

// File: tb/wave_seq_test.sv
module wave_seq_test;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, stop = 1'b0;
  logic prog_we = 1'b0; logic [4:0] prog_waddr = '0; logic [15:0] prog_wdata = '0;
  logic pat_we = 1'b0; logic [3:0] pat_wword = '0; logic [5:0] pat_wslot = '0;
  logic [15:0] pat_wdata = '0;
  logic idle_we = 1'b0; logic [15:0] idle_wdata = '0;
  logic ext_valid = 1'b0; logic [7:0] ext_data = '0;
  logic ext_ready, fwd_valid, sys_valid;
  logic [7:0] fwd_data, sys_cmd;
  logic [15:0] lines;

  wave_seq uut (.clk, .rst_n, .start, .stop, .prog_we, .prog_waddr, .prog_wdata,
    .pat_we, .pat_wword, .pat_wslot, .pat_wdata, .idle_we, .idle_wdata,
    .ext_valid, .ext_data, .ext_ready, .fwd_valid, .fwd_data, .sys_valid,
    .sys_cmd, .lines);

  always #5 clk = ~clk;

  typedef struct { logic [15:0] ln; bit pass; bit rdy; bit sys; string req; } item_t;
  item_t exq[$];
  int n_chk = 0, n_fail = 0, cyc = 0;
  bit mon_en = 1'b0, drive_ext = 1'b0, done = 1'b0;
  bit prev_rdy = 1'b0; logic [7:0] prev_data = '0;
  localparam logic [15:0] IDLE_V = 16'hA5C3;
  localparam logic [7:0]  CMD_V  = 8'h3C;

  function automatic logic [15:0] pv(int w, int s);
    return 16'((w * 16'h0111) ^ (s * 16'h0a03) ^ 16'h3c5a);
  endfunction
  function automatic logic [15:0] enc_rd(int op, int w, int c);
    return {3'(op), 1'b0, 8'(c), 4'(w)};
  endfunction
  function automatic logic [15:0] enc_loop(int c, int t);
    return {3'd2, 8'(c), 5'(t)};
  endfunction
  function automatic logic [15:0] enc_jmp(int t);
    return {3'd1, 8'd0, 5'(t)};
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic push(logic [15:0] v, bit pass, bit sys, string req);
    item_t it;
    it.ln = v; it.pass = pass; it.rdy = 1'b0; it.sys = sys; it.req = req;
    exq.push_back(it);
  endtask
  task automatic push_hold(logic [15:0] v, int n, string req);
    for (int i = 0; i < n; i++) push(v, 1'b0, 1'b0, req);
  endtask
  task automatic push_word(int w, bit pass, bit sysf, string req);
    for (int s = 0; s < 48; s++) push(pv(w, s), pass, sysf && s == 0, req);
  endtask
  task automatic finalize;
    for (int i = 0; i + 1 < exq.size(); i++) exq[i].rdy = exq[i+1].pass;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 60000 && !done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  always @(negedge clk) if (drive_ext) ext_data <= ext_data + 8'd7;

  always @(negedge clk) begin
    #1;
    if (mon_en && exq.size() > 0) begin
      item_t it;
      it = exq.pop_front();
      chk(lines == it.ln, it.req, 32'(lines), 32'(it.ln));
      chk(ext_ready == it.rdy, it.rdy ? "R9 ready" : "R8 ready", 32'(ext_ready), 32'(it.rdy));
      chk(sys_valid == it.sys, "R10 sys_valid", 32'(sys_valid), 32'(it.sys));
      if (it.sys) chk(sys_cmd == CMD_V, "R10 sys_cmd", 32'(sys_cmd), 32'(CMD_V));
      if (prev_rdy && ext_valid)
        chk(fwd_valid && fwd_data == prev_data, "R9 forward", {23'd0, fwd_valid, fwd_data},
            {24'd1, prev_data});
      else
        chk(!fwd_valid, "R8 no forward", 32'(fwd_valid), 32'd0);
      prev_rdy = ext_ready && ext_valid;
      prev_data = ext_data;
    end
  end

  task automatic wprog(int a, logic [15:0] d);
    prog_we = 1'b1; prog_waddr = 5'(a); prog_wdata = d;
    @(negedge clk); prog_we = 1'b0;
  endtask

  task automatic run_and_wait;
    finalize();
    prev_rdy = 1'b0;
    start = 1'b1;
    @(negedge clk); start = 1'b0; mon_en = 1'b1;
    wait (exq.size() == 0);
    @(negedge clk); mon_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(lines == 16'h0, "R1 lines", 32'(lines), 32'h0);
    chk(!ext_ready, "R1 ext_ready", 32'(ext_ready), 32'h0);
    chk(!fwd_valid && !sys_valid, "R1 strobes", {fwd_valid, sys_valid}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    // R6 idle level write while halted
    idle_we = 1'b1; idle_wdata = IDLE_V;
    @(negedge clk); idle_we = 1'b0;
    chk(lines == IDLE_V, "R6 idle write", 32'(lines), 32'(IDLE_V));

    for (int w = 0; w < 16; w++)
      for (int s = 0; s < 48; s++) begin
        pat_we = 1'b1; pat_wword = 4'(w); pat_wslot = 6'(s); pat_wdata = pv(w, s);
        @(negedge clk);
      end
    pat_we = 1'b0;

    // Program A: reads back to back, jump, loop with count 2, halt
    wprog(0, enc_rd(3, 1, 0));
    wprog(1, enc_rd(3, 2, 0));
    wprog(2, enc_jmp(4));
    wprog(3, 16'h0000);
    wprog(4, enc_rd(3, 3, 0));
    wprog(5, enc_loop(2, 4));
    wprog(6, 16'h0000);

    push_hold(IDLE_V, 2, "R2 idle before first slot");
    push_word(1, 0, 0, "R2 first word");
    push_word(2, 0, 0, "R3 gap-free second word");
    push_hold(pv(2, 47), 2, "R4 jump hold");
    push_word(3, 0, 0, "R5 loop pass 1");
    push_hold(pv(3, 47), 2, "R5 loop taken hold");
    push_word(3, 0, 0, "R5 loop pass 2");
    push_hold(pv(3, 47), 2, "R5 loop taken hold");
    push_word(3, 0, 0, "R5 loop pass 3");
    push_hold(pv(3, 47), 1, "R5 loop fall-through hold");
    push_hold(IDLE_V, 3, "R6 halt parks idle");
    run_and_wait();

    // R7 stop in the middle of the first word
    push_hold(IDLE_V, 2, "R7 start");
    for (int s = 0; s < 28; s++) push(pv(1, s), 1'b0, 1'b0, "R7 before stop");
    push_hold(IDLE_V, 3, "R7 parked after stop");
    finalize();
    prev_rdy = 1'b0;
    start = 1'b1;
    @(negedge clk); start = 1'b0; mon_en = 1'b1;
    repeat (29) @(negedge clk);
    stop = 1'b1;
    @(negedge clk); stop = 1'b0;
    wait (exq.size() == 0);
    @(negedge clk); mon_en = 1'b0;

    // Program B: pass read, command read, plain read, halt; commands offered throughout
    wprog(0, enc_rd(4, 0, 0));
    wprog(1, enc_rd(5, 5, CMD_V));
    wprog(2, enc_rd(3, 6, 0));
    wprog(3, 16'h0000);
    push_hold(IDLE_V, 2, "R9 start");
    push_word(0, 1, 0, "R9 pass word");
    push_word(5, 0, 1, "R10 command word");
    push_word(6, 0, 0, "R11 plain word unchanged");
    push_hold(IDLE_V, 3, "R11 idle unchanged");
    ext_valid = 1'b1; drive_ext = 1'b1;
    fork
      run_and_wait();
      begin
        repeat (10) @(negedge clk);
        prog_we = 1'b1; prog_waddr = 5'd2; prog_wdata = enc_jmp(0);
        pat_we = 1'b1; pat_wword = 4'd6; pat_wslot = 6'd0; pat_wdata = 16'hFFFF;
        idle_we = 1'b1; idle_wdata = 16'h0001;
        @(negedge clk);
        prog_we = 1'b0; pat_we = 1'b0; idle_we = 1'b0;
      end
    join
    ext_valid = 1'b0; drive_ext = 1'b0;
    chk(lines == IDLE_V, "R11 idle after run", 32'(lines), 32'(IDLE_V));

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule